// File: doc/BRIEF.md
# Modular Exponentiation Accelerator Register Front End

This block sits between a 32-bit processor bus and a modular exponentiation engine. Software sees two kinds of space through one word-addressed port. The first is a small register file: identity words, a control register, a status register, a mode register, the programmed operand widths, and two read-only capacity constants. The second is four operand windows, which hold the modulus, the message, the exponent and the result. Inside each window the least significant 32-bit word sits at the lowest address.

Software starts the engine by writing the control register. There are two operations: modulus precomputation, and exponentiation. Each operation starts only when its control bit goes from 0 to 1 between two successive writes. To start the same operation again, software writes 0 and then writes the bit again. Each start is a single-cycle pulse to the engine. The status register shows two separate completion flags, one for each operation. In this project the engine is a stub with a fixed latency. When an exponentiation finishes, the stub fills the result window with a deterministic pattern.

The request side uses valid/ready. The request fields must stay stable while `req_valid` is high and `req_ready` is low. A request is accepted on a clock edge where both signals are high. Read responses have no back-pressure. Each accepted read produces exactly one response, with `rsp_valid` high for one cycle. `req_ready` drops only while the engine is writing the result window.

Top module: `mxp_reg_front`

## Requirements
- R1: Byte address 0x000 reads 0x6D6F6465, 0x004 reads 0x78706137 and 0x008 reads the version word 0x302E3230.
- R2: An accepted read returns its data with `rsp_valid` high in the cycle after acceptance. `rsp_valid` is never high at any other time.
- R3: Control is at byte 0x020. Bit 0 starts precomputation and bit 1 starts exponentiation. A start happens only on a 0-to-1 change relative to the previous written value. If both bits rise together, only precomputation starts. The register reads back the last written value in bits 1:0.
- R4: Status is at byte 0x024, with bit 0 = ready and bit 1 = valid. Both flags are 0 after reset. Starting precomputation clears ready, and its completion sets ready. Starting exponentiation clears valid, and its completion sets valid.
- R5: A rising control bit written while the engine is busy starts nothing.
- R6: The mode register at byte 0x040 keeps only bit 1 (CRT select). All other bits read 0. The modulus width (byte 0x044) and exponent width (byte 0x048) are 32-bit read/write registers.
- R7: Byte 0x04C reads the MAX_BITS parameter (512 by default). Byte 0x050 reads the ARRAY_BITS parameter (64 by default).
- R8: Operand word i of window k is at byte 0x800 + k*0x200 + 4*i, where k = 0 is the modulus, 1 the message, 2 the exponent and 3 the result. Word 0 is the least significant word. The modulus, message and exponent windows read back what was written.
- R9: Bus writes to the result window are dropped. Reads of unmapped registers, and of window words at or beyond MAX_BITS/32, return 0.
- R10: When exponentiation completes, result word i equals modulus[i] XOR message[i] XOR exponent[i] XOR i, for every i below MAX_BITS/32.
- R11: `req_ready` is high outside the result write-out. During each exponentiation it is low for exactly MAX_BITS/32 cycles. A request held during that time is accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address, bits 1:0 ignored |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (single cycle) |
| rsp_rdata | output | 32 | Read data |

## Verification
The assertions assume that request fields are stable while `req_valid` is high and `req_ready` is low. They also assume the engine latency is at least one cycle, so that a start and its own completion never fall on the same edge. The bench drives every request on the falling edge and holds it until a falling edge where `req_ready` is high. It never issues a second request before the first is accepted. The default latency of 20 cycles keeps each start well away from its completion. The bench also deliberately writes a second rising control bit while an operation is running, which exercises the start gating.

// File: rtl/mxp_pkg.sv
package mxp_pkg;
  localparam int ADDR_W = 12;
  localparam int RIDX_W = 9;

  localparam logic [31:0] ID_WORD0 = 32'h6D6F6465;
  localparam logic [31:0] ID_WORD1 = 32'h78706137;
  localparam logic [31:0] ID_VER   = 32'h302E3230;

  localparam logic [RIDX_W-1:0] REG_ID0  = 9'h000;
  localparam logic [RIDX_W-1:0] REG_ID1  = 9'h001;
  localparam logic [RIDX_W-1:0] REG_VER  = 9'h002;
  localparam logic [RIDX_W-1:0] REG_CTRL = 9'h008;
  localparam logic [RIDX_W-1:0] REG_STAT = 9'h009;
  localparam logic [RIDX_W-1:0] REG_MODE = 9'h010;
  localparam logic [RIDX_W-1:0] REG_MODW = 9'h011;
  localparam logic [RIDX_W-1:0] REG_EXPW = 9'h012;
  localparam logic [RIDX_W-1:0] REG_CAPB = 9'h013;
  localparam logic [RIDX_W-1:0] REG_CAPA = 9'h014;

  localparam logic [1:0] BANK_RES = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_WRITE = 2'd2
  } eng_state_e;
endpackage

// File: rtl/mxp_ctrl_edge.sv
module mxp_ctrl_edge (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [1:0] ctl_wdata,
  input  logic       eng_busy,
  output logic [1:0] ctl_q,
  output logic       start_init,
  output logic       start_next
);
  logic [1:0] ctl_r;
  logic [1:0] rise;
  logic       blocked;
  logic       st_init_r;
  logic       st_next_r;

  always_comb begin
    rise    = ctl_wdata & ~ctl_r;
    // a pulse still in flight counts as busy: the engine sees it one edge later
    blocked = eng_busy | st_init_r | st_next_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_r     <= '0;
      st_init_r <= 1'b0;
      st_next_r <= 1'b0;
    end else begin
      st_init_r <= ctl_we & rise[0] & ~blocked;
      st_next_r <= ctl_we & rise[1] & ~rise[0] & ~blocked;
      if (ctl_we) ctl_r <= ctl_wdata;
    end
  end

  assign ctl_q      = ctl_r;
  assign start_init = st_init_r;
  assign start_next = st_next_r;

  AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_init, start_next})); // R3
  AST_INIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    start_init |=> !start_init); // R3
  AST_NEXT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    start_next |=> !start_next); // R3
endmodule

// File: rtl/mxp_engine_stub.sv
module mxp_engine_stub #(
  parameter int NWORDS = 16,
  parameter int IW     = 4,
  parameter int DELAY  = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_init,
  input  logic          start_next,
  output logic          busy,
  output logic          writing,
  output logic          done_init,
  output logic          done_next,
  output logic [IW-1:0] eng_idx,
  input  logic [31:0]   opnd_mod,
  input  logic [31:0]   opnd_msg,
  input  logic [31:0]   opnd_exp,
  output logic          res_we,
  output logic [IW-1:0] res_idx,
  output logic [31:0]   res_wdata
);
  import mxp_pkg::*;

  localparam int CNT_W = $clog2(DELAY + 1) + 1;

  eng_state_e    state_q;
  logic [CNT_W-1:0] cnt_q;
  logic          op_next_q;
  logic [IW-1:0] idx_q;
  logic          done_init_q;
  logic          done_next_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      op_next_q   <= 1'b0;
      idx_q       <= '0;
      done_init_q <= 1'b0;
      done_next_q <= 1'b0;
    end else begin
      done_init_q <= 1'b0;
      done_next_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_init || start_next) begin
            state_q   <= ST_WAIT;
            cnt_q     <= CNT_W'(DELAY);
            op_next_q <= start_next;
            idx_q     <= '0;
          end
        end
        ST_WAIT: begin
          if (cnt_q <= CNT_W'(1)) begin
            if (op_next_q) begin
              state_q <= ST_WRITE;
            end else begin
              state_q     <= ST_IDLE;
              done_init_q <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_WRITE: begin
          if (idx_q == IW'(NWORDS - 1)) begin
            state_q     <= ST_IDLE;
            done_next_q <= 1'b1;
          end else begin
            idx_q <= idx_q + IW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign writing   = (state_q == ST_WRITE);
  assign done_init = done_init_q;
  assign done_next = done_next_q;
  assign eng_idx   = idx_q;
  assign res_we    = writing;
  assign res_idx   = idx_q;
  assign res_wdata = opnd_mod ^ opnd_msg ^ opnd_exp ^ 32'(idx_q);

  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_init || start_next) |-> (state_q == ST_IDLE)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_init |=> !done_init); // R4
  AST_RES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> (32'(res_idx) < NWORDS)); // R10
endmodule

// File: rtl/mxp_opbank.sv
module mxp_opbank #(
  parameter int NWORDS = 16,
  parameter int IW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [1:0]    bus_bank,
  input  logic [IW-1:0] bus_idx,
  input  logic [31:0]   bus_wdata,
  input  logic [1:0]    rd_bank,
  input  logic [IW-1:0] rd_idx,
  output logic [31:0]   rd_data,
  input  logic [IW-1:0] eng_idx,
  output logic [31:0]   eng_mod,
  output logic [31:0]   eng_msg,
  output logic [31:0]   eng_exp,
  input  logic          res_we,
  input  logic [IW-1:0] res_idx,
  input  logic [31:0]   res_wdata
);
  import mxp_pkg::*;

  logic [31:0] bank_rd  [4];
  logic [31:0] bank_eng [3];

  for (genvar k = 0; k < 4; k++) begin : g_bank
    logic [31:0]   words_q [NWORDS];
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic [31:0]   wr_data;

    if (k == 3) begin : g_res
      assign wr_en   = res_we;
      assign wr_idx  = res_idx;
      assign wr_data = res_wdata;
    end else begin : g_opnd
      assign wr_en       = bus_we && (bus_bank == 2'(k));
      assign wr_idx      = bus_idx;
      assign wr_data     = bus_wdata;
      assign bank_eng[k] = words_q[eng_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < NWORDS; i++) words_q[i] <= '0;
      end else if (wr_en) begin
        words_q[wr_idx] <= wr_data;
      end
    end

    assign bank_rd[k] = words_q[rd_idx];
  end

  assign rd_data = bank_rd[rd_bank];
  assign eng_mod = bank_eng[0];
  assign eng_msg = bank_eng[1];
  assign eng_exp = bank_eng[2];

  AST_BUS_NO_RES: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> (bus_bank != BANK_RES)); // R9
  AST_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> !bus_we); // R11
endmodule

// File: rtl/mxp_reg_front.sv
module mxp_reg_front #(
  parameter int MAX_BITS   = 512,
  parameter int ARRAY_BITS = 64,
  parameter int ENG_DELAY  = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [11:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata
);
  import mxp_pkg::*;

  localparam int NWORDS = MAX_BITS / 32;
  localparam int IW     = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  logic              acc;
  logic              is_win;
  logic [1:0]        win_bank;
  logic [6:0]        win_word;
  logic              in_rng;
  logic [RIDX_W-1:0] reg_idx;
  logic              unused_lo;

  logic        win_we;
  logic        ctl_we;
  logic [31:0] win_rd;
  logic [31:0] reg_rd;
  logic [31:0] rd_next;

  logic [1:0]  ctl_q;
  logic        start_init, start_next;
  logic        eng_busy, eng_writing, done_init, done_next;
  logic [IW-1:0] eng_idx, res_idx;
  logic [31:0] eng_mod, eng_msg, eng_exp, res_wdata;
  logic        res_we;

  logic        ready_q, valid_q, crt_q;
  logic [31:0] modw_q, expw_q;
  logic        rsp_valid_q;
  logic [31:0] rsp_data_q;

  assign unused_lo = ^req_addr[1:0];
  assign req_ready = ~eng_writing;
  assign acc       = req_valid & req_ready;
  assign is_win    = req_addr[11];
  assign win_bank  = req_addr[10:9];
  assign win_word  = req_addr[8:2];
  assign in_rng    = (32'(win_word) < NWORDS);
  assign reg_idx   = req_addr[10:2];

  assign win_we = acc & req_write & is_win & in_rng & (win_bank != BANK_RES);
  assign ctl_we = acc & req_write & ~is_win & (reg_idx == REG_CTRL);

  mxp_ctrl_edge u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_we     (ctl_we),
    .ctl_wdata  (req_wdata[1:0]),
    .eng_busy   (eng_busy),
    .ctl_q      (ctl_q),
    .start_init (start_init),
    .start_next (start_next)
  );

  mxp_engine_stub #(.NWORDS(NWORDS), .IW(IW), .DELAY(ENG_DELAY)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_init (start_init),
    .start_next (start_next),
    .busy       (eng_busy),
    .writing    (eng_writing),
    .done_init  (done_init),
    .done_next  (done_next),
    .eng_idx    (eng_idx),
    .opnd_mod   (eng_mod),
    .opnd_msg   (eng_msg),
    .opnd_exp   (eng_exp),
    .res_we     (res_we),
    .res_idx    (res_idx),
    .res_wdata  (res_wdata)
  );

  mxp_opbank #(.NWORDS(NWORDS), .IW(IW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (win_we),
    .bus_bank  (win_bank),
    .bus_idx   (win_word[IW-1:0]),
    .bus_wdata (req_wdata),
    .rd_bank   (win_bank),
    .rd_idx    (win_word[IW-1:0]),
    .rd_data   (win_rd),
    .eng_idx   (eng_idx),
    .eng_mod   (eng_mod),
    .eng_msg   (eng_msg),
    .eng_exp   (eng_exp),
    .res_we    (res_we),
    .res_idx   (res_idx),
    .res_wdata (res_wdata)
  );

  always_comb begin
    reg_rd = '0;
    case (reg_idx)
      REG_ID0:  reg_rd = ID_WORD0;
      REG_ID1:  reg_rd = ID_WORD1;
      REG_VER:  reg_rd = ID_VER;
      REG_CTRL: reg_rd = {30'b0, ctl_q};
      REG_STAT: reg_rd = {30'b0, valid_q, ready_q};
      REG_MODE: reg_rd = {30'b0, crt_q, 1'b0};
      REG_MODW: reg_rd = modw_q;
      REG_EXPW: reg_rd = expw_q;
      REG_CAPB: reg_rd = 32'(MAX_BITS);
      REG_CAPA: reg_rd = 32'(ARRAY_BITS);
      default:  reg_rd = '0;
    endcase
    if (is_win) rd_next = in_rng ? win_rd : '0;
    else        rd_next = reg_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q     <= 1'b0;
      valid_q     <= 1'b0;
      crt_q       <= 1'b0;
      modw_q      <= '0;
      expw_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      // a fresh start wins over a completion landing on the same edge
      if (start_init)     ready_q <= 1'b0;
      else if (done_init) ready_q <= 1'b1;
      if (start_next)     valid_q <= 1'b0;
      else if (done_next) valid_q <= 1'b1;

      if (acc && req_write && !is_win) begin
        case (reg_idx)
          REG_MODE: crt_q  <= req_wdata[1];
          REG_MODW: modw_q <= req_wdata;
          REG_EXPW: expw_q <= req_wdata;
          default: ;
        endcase
      end

      rsp_valid_q <= acc & ~req_write;
      if (acc && !req_write) rsp_data_q <= rd_next;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_data_q;

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write) |=> rsp_valid); // R2
  AST_RSP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(acc && !req_write)); // R2
  AST_READY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    start_init |=> !ready_q); // R4
  AST_VALID_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    start_next |=> !valid_q); // R4
  AST_STALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> eng_busy); // R11
endmodule

// File: tb/tb_mxp_reg_front.sv
module tb_mxp_reg_front;
  localparam int MAXB = 512;
  localparam int ARRB = 64;
  localparam int DLY  = 20;
  localparam int NW   = MAXB / 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;

  always #10 clk = ~clk;

  mxp_reg_front #(.MAX_BITS(MAXB), .ARRAY_BITS(ARRB), .ENG_DELAY(DLY)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  typedef struct {
    logic [31:0] expv;
    logic        chk;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  int          errs = 0;
  int          checks = 0;
  logic [31:0] last_rd = '0;
  int          stall_cnt = 0;

  function automatic logic [11:0] win(input int k, input int i);
    return 12'(32'h800 + k * 32'h200 + i * 4);
  endfunction
  function automatic logic [31:0] fmod(input int i);
    return 32'h9E3779B9 * 32'(i + 1);
  endfunction
  function automatic logic [31:0] fmsg(input int i, input logic [31:0] s);
    return 32'h7F4A7C15 ^ (32'(i) << 8) ^ s;
  endfunction
  function automatic logic [31:0] fexp(input int i);
    return ~(32'h01000193 * 32'(i + 3));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor: pops scoreboard entries as responses appear
  always @(negedge clk) begin
    item_t it;
    if (rst_n && !req_ready) stall_cnt++;
    if (rst_n && rsp_valid) begin
      if (sb_q.size() == 0) begin
        checks++;
        errs++;
        $display("FAIL R2 unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        it = sb_q.pop_front();
        last_rd = rsp_rdata;
        if (it.chk) chk(it.tag, rsp_rdata, it.expv);
      end
    end
  end

  task automatic bus(input logic wr, input logic [11:0] a, input logic [31:0] d,
                     input logic do_chk, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    if (!wr) begin
      it.expv = e; it.chk = do_chk; it.tag = tag;
      sb_q.push_back(it);
    end
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus(1'b1, a, d, 1'b0, '0, "");
  endtask
  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    bus(1'b0, a, '0, 1'b1, e, tag);
  endtask
  task automatic rd_raw(input logic [11:0] a, output logic [31:0] v);
    bus(1'b0, a, '0, 1'b0, '0, "");
    wait (sb_q.size() == 0);
    #1;
    v = last_rd;
  endtask
  task automatic poll(input int bitpos, input string tag);
    logic [31:0] s;
    s = '0;
    for (int n = 0; n < 300; n++) begin
      rd_raw(12'h024, s);
      if (s[bitpos]) break;
    end
    chk(tag, 32'(s[bitpos]), 32'd1);
  endtask

  task automatic run_exp(input logic [31:0] seed);
    for (int i = 0; i < NW; i++) wr(win(1, i), fmsg(i, seed));
    wr(12'h020, 32'd0);
    wr(12'h020, 32'd2);
    repeat (3) @(negedge clk);
    rd(12'h024, 32'h1, "R4 valid cleared by exponent start");
    poll(1, "R4 valid set on completion");
    for (int i = 0; i < NW; i++)
      rd(win(3, i), fmod(i) ^ fmsg(i, seed) ^ fexp(i) ^ 32'(i), "R10 result word");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 ready after reset", 32'(req_ready), 32'd1);
    chk("R2 no response after reset", 32'(rsp_valid), 32'd0);

    rd(12'h000, 32'h6D6F6465, "R1 id word 0");
    rd(12'h004, 32'h78706137, "R1 id word 1");
    rd(12'h008, 32'h302E3230, "R1 version");
    rd(12'h024, 32'h0, "R4 status after reset");
    rd(12'h04C, 32'(MAXB), "R7 max bits");
    rd(12'h050, 32'(ARRB), "R7 array bits");
    rd(12'h014, 32'h0, "R9 unmapped word 5");
    rd(12'h080, 32'h0, "R9 unmapped word 0x20");

    wr(12'h040, 32'hFFFF_FFFF);
    rd(12'h040, 32'h2, "R6 mode keeps bit 1 only");
    wr(12'h044, 32'd384);
    wr(12'h048, 32'd512);
    rd(12'h044, 32'd384, "R6 modulus width");
    rd(12'h048, 32'd512, "R6 exponent width");

    for (int i = 0; i < NW; i++) begin
      wr(win(0, i), fmod(i));
      wr(win(2, i), fexp(i));
    end
    rd(12'h800, fmod(0), "R8 modulus word 0 at window base");
    rd(win(0, NW - 1), fmod(NW - 1), "R8 modulus top word");
    rd(win(2, 5), fexp(5), "R8 exponent word 5");
    rd(win(0, NW), 32'h0, "R9 beyond window depth");
    wr(win(3, 0), 32'hDEADBEEF);
    rd(win(3, 0), 32'h0, "R9 result write dropped");

    wr(12'h020, 32'd0);
    wr(12'h020, 32'd1);
    wr(12'h020, 32'd3);
    rd(12'h020, 32'd3, "R3 control readback");
    poll(0, "R4 ready set after precompute");
    repeat (2 * DLY + NW + 10) @(negedge clk);
    rd(12'h024, 32'h1, "R5 exponent rise during busy ignored");

    wr(12'h020, 32'd1);
    rd(12'h024, 32'h1, "R3 level without edge, immediate");
    repeat (DLY + 5) @(negedge clk);
    rd(12'h024, 32'h1, "R3 level without edge, later");

    wr(12'h020, 32'd0);
    wr(12'h020, 32'd1);
    repeat (3) @(negedge clk);
    rd(12'h024, 32'h0, "R4 ready cleared by precompute start");
    poll(0, "R4 ready set again");

    wr(12'h020, 32'd0);
    wr(12'h020, 32'd3);
    repeat (DLY + NW + 10) @(negedge clk);
    rd(12'h024, 32'h1, "R3 both bits rise: only precompute runs");

    wr(win(1, 0), 32'h1234_5678);
    rd(win(1, 0), 32'h1234_5678, "R8 message word 0");

    stall_cnt = 0;
    run_exp(32'h0000_0000);
    chk("R11 stall cycles per exponentiation", 32'(stall_cnt), 32'(NW));
    run_exp(32'hA5A5_0F0F);
    rd(12'h024, 32'h3, "R4 both flags set");
    rd(win(0, 3), fmod(3), "R8 modulus kept after runs");

    wait (sb_q.size() == 0);
    repeat (2) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule